// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Access Engine

This block is the serial-slave front end of a real-time-clock register bank. A host on a four-wire serial link (SPI mode 0) sends single-byte commands. Some commands set or clear a write-enable latch. Others start a read or write burst over a bank of 8-bit clock registers. The whole block runs on one system clock. The serial clock, select and data lines are synchronised and edge-detected inside the block, so the serial clock must be several times slower than the system clock.

Writes first land in a staging copy of the bank. Only register 0 is open to writes while the lock bit W (bit 1 of register 0) is low. While W is high, any register may be staged. When W falls from 1 to 0, the whole staging bank is copied to the live bank in one cycle. The live bank is presented in parallel to the timekeeping logic and is also what the read command returns.

Top module: `rtc_spi_engine`

## Requirements
- R1: After reset all live registers read 0x00, the write-enable latch is 0 and the serial output enable is 0.
- R2: The 8-bit command 0x06 sets the write-enable latch and the command 0x04 clears it. Neither command takes an address. Every byte is sent MSB first and sampled on the rising serial clock.
- R3: The write command 0x12 has no effect on any register when the write-enable latch is 0 at the time its opcode completes.
- R4: When a write command accepted with the latch set ends (the select line returns high), the write-enable latch reads 0.
- R5: A data byte written to a register other than 0 while W is 0 is discarded: a later commit leaves that register at its previous value.
- R6: Bytes written while W is 1 do not change the live registers. On the byte that takes W from 1 to 0, all staged values, including the new register 0 byte, appear on the live bank together.
- R7: W is bit 1 of register 0. A write to register 0 updates W in the live bank at once, whatever the state of W.
- R8: After each data byte of a burst the register address increments, and after 0x0F it wraps to 0x00.
- R9: The read command 0x13, followed by an address byte, shifts live register contents out MSB first. A new bit is presented after each falling serial clock edge. Successive bytes come from incrementing, wrapping addresses.
- R10: The serial output enable is 1 only during the data phase of a read command. It is 0 throughout write frames.
- R11: A select-line rise in the middle of a byte discards that partial byte. No register changes.
- R12: An unknown opcode is ignored until the select line rises. It leaves the latch and the registers unchanged and keeps the output disabled.
- R13: Only the low four bits of the address byte select a register. The upper four bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low select; a rise ends or aborts a frame |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = high impedance) |
| wr_latch | output | 1 | Current write-enable latch |
| rtc_live | output | 128 | Live registers; register i is bits [8i+7:8i] |

## Verification
Every serial edge reaches the logic after the synchroniser depth plus one edge-detect stage, which is three system clocks by default. A register write or commit shows on rtc_live one clock after that, and a read bit shows on spi_miso one clock after the detected falling edge. The bench holds each serial clock level for eight system clocks. It samples spi_miso just before the rising edge, as a mode-0 host would. It checks rtc_live, wr_latch and the output enable only after a full half-period, or after the select line has been high for two half-periods, so every result is already settled well inside its latency.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t OP_LATCH_SET = 8'h06;
  localparam byte_t OP_LATCH_CLR = 8'h04;
  localparam byte_t OP_REG_WRITE = 8'h12;
  localparam byte_t OP_REG_READ  = 8'h13;

  // lock bit position inside register 0
  localparam int LOCK_BIT = 1;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDRESS,
    PH_WR_DATA,
    PH_RD_DATA,
    PH_IDLE_OUT
  } phase_e;
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic cs_n_in,
  input  logic sdi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_end,
  output logic sel,
  output logic sdi
);
  localparam logic [2:0] IDLE_VAL = 3'b010;

  logic [2:0] pipe_q [STAGES];
  logic [1:0] last_q;
  logic [2:0] cur;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= IDLE_VAL;
      else if (g == 0) pipe_q[g] <= {sck_in, cs_n_in, sdi_in};
      else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g - 1];
    end
  end

  assign cur = pipe_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDLE_VAL[2:1];
    else        last_q <= cur[2:1];
  end

  assign sel      = ~cur[1];
  assign sck_rise = cur[2] & ~last_q[1] & sel;
  assign sck_fall = ~cur[2] & last_q[1] & sel;
  assign sel_end  = cur[1] & ~last_q[0];
  assign sdi      = cur[0];
endmodule

// File: rtl/rtc_spi_frame.sv
module rtc_spi_frame
  import rtc_spi_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          sel_end,
  input  logic          sel,
  input  logic          sdi,
  input  byte_t         rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output byte_t         wr_data,
  output logic          miso,
  output logic          miso_oe,
  output logic          wel
);
  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  phase_e        phase_q;
  logic [2:0]    bit_q;
  logic [6:0]    rx_q;
  logic [6:0]    tx_q;
  logic [AW-1:0] addr_q;
  logic          miso_q, wel_q, wr_cmd_q;

  logic  byte_done;
  byte_t rx_byte;

  assign rx_byte   = {rx_q, sdi};
  assign byte_done = sck_rise && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_OPCODE;
      bit_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      addr_q   <= '0;
      miso_q   <= 1'b0;
      wel_q    <= 1'b0;
      wr_cmd_q <= 1'b0;
    end else if (!sel) begin
      if (sel_end && wr_cmd_q) wel_q <= 1'b0;
      phase_q  <= PH_OPCODE;
      bit_q    <= '0;
      wr_cmd_q <= 1'b0;
      miso_q   <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_q  <= rx_byte[6:0];
        bit_q <= bit_q + 3'd1;
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_OPCODE: begin
            phase_q <= PH_IDLE_OUT;
            case (rx_byte)
              OP_LATCH_SET: wel_q <= 1'b1;
              OP_LATCH_CLR: wel_q <= 1'b0;
              OP_REG_WRITE: if (wel_q) begin
                phase_q  <= PH_ADDRESS;
                wr_cmd_q <= 1'b1;
              end
              OP_REG_READ:  phase_q <= PH_ADDRESS;
              default:      phase_q <= PH_IDLE_OUT;
            endcase
          end
          PH_ADDRESS: begin
            addr_q  <= rx_byte[AW-1:0];
            phase_q <= wr_cmd_q ? PH_WR_DATA : PH_RD_DATA;
          end
          PH_WR_DATA, PH_RD_DATA: addr_q <= addr_step(addr_q);
          default: ;
        endcase
      end
      if (sck_fall && phase_q == PH_RD_DATA) begin
        if (bit_q == 3'd0) begin
          miso_q <= rd_data[7];
          tx_q   <= rd_data[6:0];
        end else begin
          miso_q <= tx_q[6];
          tx_q   <= {tx_q[5:0], 1'b0};
        end
      end
    end
  end

  assign rd_addr = addr_q;
  assign wr_stb  = byte_done && phase_q == PH_WR_DATA;
  assign wr_addr = addr_q;
  assign wr_data = rx_byte;
  assign miso    = miso_q;
  assign miso_oe = sel && phase_q == PH_RD_DATA;
  assign wel     = wel_q;

  // R2
  latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && byte_done && phase_q == PH_OPCODE && rx_byte == OP_LATCH_SET) |=> wel);
  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && byte_done && phase_q == PH_OPCODE && rx_byte == OP_REG_WRITE && !wel_q)
      |=> phase_q == PH_IDLE_OUT);
  // R4
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_end && wr_cmd_q) |=> !wel);
  // R8
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && byte_done && (phase_q == PH_WR_DATA || phase_q == PH_RD_DATA) && addr_q == '1)
      |=> addr_q == '0);
  // R10
  quiet_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !miso_oe);
endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_spi_pkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [AW-1:0]         wr_addr,
  input  byte_t                 wr_data,
  input  logic [AW-1:0]         rd_addr,
  output byte_t                 rd_data,
  output logic [NREG-1:0][7:0]  live
);
  logic [NREG-1:0][7:0] live_q, stage_q;
  logic lock_open, reg0_wr, commit;

  assign lock_open = live_q[0][LOCK_BIT];
  assign reg0_wr   = wr_stb && wr_addr == '0;
  assign commit    = reg0_wr && lock_open && !wr_data[LOCK_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= '0;
      stage_q <= '0;
    end else if (reg0_wr) begin
      stage_q[0]           <= wr_data;
      live_q[0][LOCK_BIT]  <= wr_data[LOCK_BIT];
      if (commit) begin
        live_q[0] <= wr_data;
        for (int i = 1; i < NREG; i++) live_q[i] <= stage_q[i];
      end
    end else if (wr_stb && lock_open) begin
      stage_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = live_q[rd_addr];
  assign live    = live_q;

  // R5
  locked_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr != '0 && !lock_open) |=> $stable(stage_q));
  // R6
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> live_q[NREG-1] == $past(stage_q[NREG-1]));
  // R6
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg0_wr |=> $stable(live_q));
  // R7
  lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg0_wr |=> live_q[0][LOCK_BIT] == $past(wr_data[LOCK_BIT]));
endmodule

// File: rtl/rtc_spi_engine.sv
module rtc_spi_engine
  import rtc_spi_pkg::*;
#(
  parameter int NREG        = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              wr_latch,
  output logic [NREG*8-1:0] rtc_live
);
  logic sck_rise, sck_fall, sel_end, sel, sdi;
  logic wr_stb;
  logic [AW-1:0] wr_addr, rd_addr;
  byte_t wr_data, rd_data;
  logic [NREG-1:0][7:0] live;

  rtc_spi_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .sck_in(spi_sck), .cs_n_in(spi_cs_n),
    .sdi_in(spi_mosi), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_end(sel_end), .sel(sel), .sdi(sdi)
  );

  rtc_spi_frame #(.AW(AW)) frame_i (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_end(sel_end), .sel(sel), .sdi(sdi), .rd_data(rd_data),
    .rd_addr(rd_addr), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .miso(spi_miso), .miso_oe(spi_miso_oe), .wel(wr_latch)
  );

  rtc_reg_bank #(.NREG(NREG), .AW(AW)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .live(live)
  );

  assign rtc_live = live;
endmodule

// File: tb/rtc_spi_engine_tb.sv
module rtc_spi_engine_tb_top;
  typedef logic [7:0] u8;
  localparam int HALF = 8;
  localparam logic [11:0] VEC [8] = '{12'h1_3A, 12'h2_5C, 12'h3_81, 12'h4_FF,
                                      12'h7_24, 12'h9_C3, 12'hC_0F, 12'hF_96};

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0;
  logic miso, miso_oe, wr_latch;
  logic [127:0] rtc_live;

  int nchk = 0, nfail = 0;
  bit done = 0;
  u8 m_live [16];
  u8 m_stage [16];
  bit m_wel = 0;

  rtc_spi_engine dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .wr_latch(wr_latch), .rtc_live(rtc_live)
  );

  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_vec();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = m_live[i];
    return v;
  endfunction

  // model of one accepted data byte, written from the requirements
  task automatic model_write(input logic [3:0] a, input u8 d);
    if (a == 0) begin
      bit was_open = m_live[0][1];
      m_stage[0]   = d;
      m_live[0][1] = d[1];
      if (was_open && !d[1]) begin
        for (int i = 1; i < 16; i++) m_live[i] = m_stage[i];
        m_live[0] = d;
      end
    end else if (m_live[0][1]) begin
      m_stage[a] = d;
    end
  endtask

  task automatic xfer(input u8 tx, output u8 rx);
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      tick(HALF);
      rx[b] = miso;
      sck = 1;
      tick(HALF);
      sck = 0;
    end
  endtask

  task automatic open_frame();
    cs_n = 0;
    tick(HALF);
  endtask

  task automatic close_frame();
    tick(HALF);
    cs_n = 1;
    tick(2 * HALF);
  endtask

  task automatic cmd(input u8 op);
    u8 rx;
    open_frame();
    xfer(op, rx);
    close_frame();
    if (op == 8'h06) m_wel = 1;
    if (op == 8'h04) m_wel = 0;
  endtask

  task automatic wr_burst(input u8 a, input int n, input u8 d [4]);
    u8 rx;
    logic [3:0] idx = a[3:0];
    bit ok = m_wel;
    open_frame();
    xfer(8'h12, rx);
    xfer(a, rx);
    check("R10 oe during write", {127'b0, miso_oe}, 128'b0);
    for (int k = 0; k < n; k++) begin
      xfer(d[k], rx);
      if (ok) model_write(idx, d[k]);
      idx = idx + 4'd1;
    end
    close_frame();
    if (ok) m_wel = 0;
  endtask

  task automatic wr_one(input u8 a, input u8 d);
    cmd(8'h06);
    wr_burst(a, 1, '{d, 8'h00, 8'h00, 8'h00});
  endtask

  task automatic rd_burst(input u8 a, input int n, input string req);
    u8 rx;
    logic [3:0] idx = a[3:0];
    open_frame();
    xfer(8'h13, rx);
    xfer(a, rx);
    check("R10 oe during read", {127'b0, miso_oe}, 128'd1);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx);
      check(req, {120'b0, rx}, {120'b0, m_live[idx]});
      idx = idx + 4'd1;
    end
    close_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    u8 rx;
    for (int i = 0; i < 16; i++) begin m_live[i] = 0; m_stage[i] = 0; end
    tick(5);
    rst_n = 1;
    tick(5);

    // R1 reset state
    check("R1 live", rtc_live, 128'b0);
    check("R1 latch", {127'b0, wr_latch}, 128'b0);
    check("R1 oe", {127'b0, miso_oe}, 128'b0);

    // vector walk: stage each entry with W=1, check nothing moved, then commit (R6, R7)
    wr_one(8'h00, 8'h02);
    check("R7 lock bit visible", rtc_live, model_vec());
    foreach (VEC[v]) begin
      wr_one({4'h0, VEC[v][11:8]}, VEC[v][7:0]);
      check("R6 staged not live", rtc_live, model_vec());
    end
    wr_one(8'h00, 8'h00);
    check("R6 commit all", rtc_live, model_vec());
    foreach (VEC[v]) check("R6 vector value", {120'b0, rtc_live[VEC[v][11:8]*8 +: 8]}, {120'b0, VEC[v][7:0]});
    rd_burst(8'h00, 16, "R9 read full bank");

    // R2 latch set and clear
    cmd(8'h06);
    check("R2 latch set", {127'b0, wr_latch}, 128'd1);
    cmd(8'h04);
    check("R2 latch clear", {127'b0, wr_latch}, 128'b0);

    // R3 write without latch
    wr_burst(8'h00, 1, '{8'h02, 8'h00, 8'h00, 8'h00});
    check("R3 rejected write", rtc_live, model_vec());

    // R4 latch drops after write, R7 lock immediate
    wr_one(8'h00, 8'h02);
    check("R4 latch after write", {127'b0, wr_latch}, 128'b0);
    check("R7 lock set", {127'b0, rtc_live[1]}, 128'd1);

    // R8 burst wrap from 0x0E; register 0 byte keeps W set
    cmd(8'h06);
    wr_burst(8'h0E, 4, '{8'hA1, 8'hB2, 8'h06, 8'hD4});
    check("R8 before commit", rtc_live, model_vec());
    wr_one(8'h00, 8'h04);
    check("R8 wrapped burst committed", rtc_live, model_vec());
    check("R8 reg1", {120'b0, rtc_live[15:8]}, {120'b0, 8'hD4});
    rd_burst(8'h0F, 3, "R9 wrapped read");

    // R5 write to locked register discarded
    wr_one(8'h05, 8'h77);
    wr_one(8'h00, 8'h02);
    wr_one(8'h00, 8'h00);
    check("R5 locked write discarded", rtc_live, model_vec());

    // R13 upper address bits ignored
    wr_one(8'h00, 8'h02);
    wr_one(8'hF3, 8'h5A);
    wr_one(8'h00, 8'h00);
    check("R13 reg3 via 0xF3", {120'b0, rtc_live[31:24]}, {120'b0, 8'h5A});

    // R11 abort mid byte
    wr_one(8'h00, 8'h02);
    cmd(8'h06);
    open_frame();
    xfer(8'h12, rx);
    xfer(8'h03, rx);
    for (int b = 0; b < 4; b++) begin
      mosi = 1; tick(HALF); sck = 1; tick(HALF); sck = 0;
    end
    close_frame();
    m_wel = 0;
    wr_one(8'h00, 8'h00);
    check("R11 partial byte dropped", rtc_live, model_vec());

    // R12 unknown opcode
    cmd(8'h06);
    open_frame();
    xfer(8'hA5, rx);
    xfer(8'h00, rx);
    check("R12 oe stays off", {127'b0, miso_oe}, 128'b0);
    xfer(8'h02, rx);
    close_frame();
    check("R12 latch kept", {127'b0, wr_latch}, 128'd1);
    check("R12 regs kept", rtc_live, model_vec());
    cmd(8'h04);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule